// File: doc/BRIEF.md
# Framed Dual-Strobe Serial Port

This block is the digital serial port of a sampling converter. An external host supplies a serial clock and two frame strobes: one that arms a read of the latest conversion result, and one that arms a write of a control word. Reads shift the result out on rising clock edges. Writes sample the data input on falling clock edges. The output enable drops after a fixed number of read clocks. The control register changes only once a write frame has run its full length, so a write cut short leaves it alone.

All logic runs on a fast system clock. The serial clock, both strobes and the data input pass through two-flop synchronisers, and the port acts on edges detected there. The converter core hands over results on a parallel word with a valid strobe. Every word is accepted in the cycle it is offered, so there is no back-pressure and no ready signal. A frame already in progress keeps the word it loaded when it was armed.

Until the matching strobe edge has armed a frame, clock activity is ignored, so the strobes act as chip selects on a shared bus. Both strobes may be tied to a single start-of-conversion line: its falling edge opens a write and its rising edge opens a read.

Top module: `framed_serial_port`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0 and `ctrl_word` is all zeros.
- R2: Serial clock edges that arrive before any strobe has armed a frame change neither `dout_oe`, `dout` nor `ctrl_word`.
- R3: A rising edge on `rfs` arms a read. The first serial clock rising edge after it sets `dout_oe` to 1 and presents bit 9 (the MSB) of the result on `dout`.
- R4: Each further serial clock rising edge during a read presents the next lower result bit, down to bit 0 on the 10th edge.
- R5: The 11th rising edge of a read sets `dout_oe` to 0. Later rising edges leave the output released until `rfs` rises again.
- R6: A result offered with `res_valid` is stored at once. The read shift register is loaded from the stored result when the read is armed, so a new result during a frame does not change the bits of that frame; it is sent by the next read.
- R7: A falling edge on `tfs` arms a write. `din` is sampled on each serial clock falling edge after it. The first sampled bit becomes `ctrl_word[9]`, the tenth becomes `ctrl_word[0]`, and any further samples are discarded.
- R8: `ctrl_word` takes the captured word on the 13th serial clock rising edge of a write. A write with fewer rising edges leaves `ctrl_word` unchanged.
- R9: A new arming edge on the same strobe during an active frame aborts it. For a read this releases `dout_oe` at once. In both cases the edge count restarts from zero.
- R10: With `rfs` and `tfs` driven by one signal, a falling edge followed by 13 clocks writes the control word, and the following rising edge followed by 11 clocks reads the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data | input | 10 | Conversion result word |
| res_valid | input | 1 | Result word is valid this cycle (always accepted) |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| rfs | input | 1 | Read frame strobe, rising edge arms a read |
| tfs | input | 1 | Write frame strobe, falling edge arms a write |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output, 0 while released |
| dout_oe | output | 1 | Output enable for the external tri-state driver |
| ctrl_word | output | 10 | Control register |

## Verification
A pin edge passes two synchroniser flops and one edge-detect stage, and the frame logic registers its result in the next cycle. So `dout`, `dout_oe` and `ctrl_word` settle about three system clocks after the serial clock edge that moves them. The bench holds each serial clock phase for eight system clocks and samples the outputs at the end of the phase, well after that latency and before the opposite edge. A stored result reaches a read one cycle after `res_valid`, and the bench leaves several cycles between loading a result and arming a read.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  // positions of the asynchronous pins inside the synchroniser vector
  localparam int PIN_SCLK = 0;
  localparam int PIN_RFS  = 1;
  localparam int PIN_TFS  = 2;
  localparam int PIN_DIN  = 3;
  localparam int PIN_N    = 4;

  localparam int DEF_RES_W   = 10;
  localparam int DEF_RD_EDGE = 11;
  localparam int DEF_WR_EDGE = 13;
endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain_q <= {STAGES{IDLE[i]}};
        last_q  <= IDLE[i];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw[i]};
        last_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl[i]  = chain_q[STAGES-1];
    assign rise[i] = chain_q[STAGES-1] & ~last_q;
    assign fall[i] = ~chain_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/fsp_rd_path.sv
module fsp_rd_path #(
  parameter int RES_W = 10,
  parameter int RD_EDGE = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  input  logic             arm,
  input  logic             tick,
  output logic             dout,
  output logic             dout_oe
);
  localparam int CW = $clog2(RD_EDGE + 1);
  localparam logic [CW-1:0] LAST = CW'(RD_EDGE - 1);

  logic [RES_W-1:0] hold_q;
  logic [RES_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q;
  logic             armed_q;
  logic             oe_q;
  logic             bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      if (res_valid) hold_q <= res_data;
      if (arm) begin
        // snapshot the result now: later conversions cannot disturb this frame
        armed_q <= 1'b1;
        cnt_q   <= '0;
        sh_q    <= hold_q;
        oe_q    <= 1'b0;
        bit_q   <= 1'b0;
      end else if (armed_q && tick) begin
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          oe_q    <= 1'b0;
          bit_q   <= 1'b0;
          cnt_q   <= '0;
        end else begin
          oe_q  <= 1'b1;
          bit_q <= sh_q[RES_W-1];
          sh_q  <= {sh_q[RES_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign dout    = bit_q;
  assign dout_oe = oe_q;

  p_oe_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(tick && armed_q));
  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !oe_q);
  p_bit_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !arm) |=> $stable(bit_q));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !oe_q);
endmodule

// File: rtl/fsp_wr_path.sv
module fsp_wr_path #(
  parameter int CTRL_W = 10,
  parameter int WR_EDGE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int FCW = $clog2(CTRL_W + 1);
  localparam int RCW = $clog2(WR_EDGE + 1);
  localparam logic [FCW-1:0] FULL = FCW'(CTRL_W);
  localparam logic [RCW-1:0] LAST = RCW'(WR_EDGE - 1);

  logic [CTRL_W-1:0] sh_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [FCW-1:0]    nf_q;
  logic [RCW-1:0]    nr_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      ctrl_q  <= '0;
      nf_q    <= '0;
      nr_q    <= '0;
      armed_q <= 1'b0;
    end else if (arm) begin
      armed_q <= 1'b1;
      nf_q    <= '0;
      nr_q    <= '0;
      sh_q    <= '0;
    end else if (armed_q) begin
      // surplus samples past the word width are dropped
      if (fall && nf_q != FULL) begin
        sh_q <= {sh_q[CTRL_W-2:0], din};
        nf_q <= nf_q + 1'b1;
      end
      if (rise) begin
        if (nr_q == LAST) begin
          ctrl_q  <= sh_q;
          armed_q <= 1'b0;
          nr_q    <= '0;
        end else begin
          nr_q <= nr_q + 1'b1;
        end
      end
    end
  end

  assign ctrl = ctrl_q;

  p_ctrl_only_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && armed_q) |=> $stable(ctrl_q));
  p_sample_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nf_q <= FULL);
  p_rise_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nr_q <= LAST);
  p_idle_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm) |=> $stable(ctrl_q));
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port #(
  parameter int RES_W = fsp_pkg::DEF_RES_W,
  parameter int RD_EDGE = fsp_pkg::DEF_RD_EDGE,
  parameter int WR_EDGE = fsp_pkg::DEF_WR_EDGE,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  input  logic             sclk,
  input  logic             rfs,
  input  logic             tfs,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  output logic [RES_W-1:0] ctrl_word
);
  import fsp_pkg::*;

  // idle levels: clock low, read strobe low, write strobe high, data low
  localparam logic [PIN_N-1:0] IDLE = PIN_N'(1 << PIN_TFS);

  logic [PIN_N-1:0] raw, lvl, rise, fall;
  logic             sync_unused;

  always_comb begin
    raw           = '0;
    raw[PIN_SCLK] = sclk;
    raw[PIN_RFS]  = rfs;
    raw[PIN_TFS]  = tfs;
    raw[PIN_DIN]  = din;
  end

  fsp_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .IDLE(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw), .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign sync_unused = ^{lvl[PIN_SCLK], lvl[PIN_RFS], lvl[PIN_TFS], rise[PIN_TFS],
                         fall[PIN_RFS], rise[PIN_DIN], fall[PIN_DIN]};

  fsp_rd_path #(.RES_W(RES_W), .RD_EDGE(RD_EDGE)) u_rd (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .arm(rise[PIN_RFS]), .tick(rise[PIN_SCLK]), .dout(dout), .dout_oe(dout_oe)
  );

  fsp_wr_path #(.CTRL_W(RES_W), .WR_EDGE(WR_EDGE)) u_wr (
    .clk(clk), .rst_n(rst_n), .arm(fall[PIN_TFS]), .rise(rise[PIN_SCLK]),
    .fall(fall[PIN_SCLK]), .din(lvl[PIN_DIN]), .ctrl(ctrl_word)
  );

  p_out_zero_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);
endmodule

// File: tb/sim_framed_serial_port.sv
module sim_framed_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] res_data = '0;
  logic       res_valid = 1'b0;
  logic       sclk = 1'b0, rfs = 1'b0, tfs = 1'b1, din = 1'b0;
  logic       dout, dout_oe;
  logic [9:0] ctrl_word;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_ctrl = '0;

  always #5 clk = ~clk;

  framed_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .sclk(sclk), .rfs(rfs), .tfs(tfs), .din(din),
    .dout(dout), .dout_oe(dout_oe), .ctrl_word(ctrl_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_result(input logic [9:0] v);
    res_data = v; res_valid = 1'b1;
    waitn(1);
    res_valid = 1'b0;
    waitn(4);
  endtask

  task automatic arm_read();
    rfs = 1'b0; waitn(6);
    rfs = 1'b1; waitn(8);
  endtask

  task automatic arm_write();
    tfs = 1'b1; waitn(6);
    tfs = 1'b0; waitn(8);
  endtask

  // n rising edges of a read, checked bit by bit; edge numbers start at first
  task automatic rd_bits(input logic [9:0] v, input int first, input int last);
    for (int k = first; k <= last; k++) begin
      sclk = 1'b1; waitn(8);
      if (k <= 10) begin
        chk(dout_oe === 1'b1, "R3 oe during read", dout_oe, 1);
        chk(dout === v[10-k], k == 1 ? "R3 msb first" : "R4 next bit", dout, v[10-k]);
      end else begin
        chk(dout_oe === 1'b0, k == 11 ? "R5 release on 11th" : "R5 extra clocks ignored",
            dout_oe, 0);
      end
      sclk = 1'b0; waitn(8);
    end
  endtask

  // full write frame body: 13 rising edges, data on falling edges, junk past bit 0
  task automatic wr_bits(input logic [9:0] w);
    for (int k = 1; k <= 13; k++) begin
      sclk = 1'b1; waitn(8);
      if (k < 13) chk(ctrl_word === exp_ctrl, "R8 no commit before 13th", ctrl_word, exp_ctrl);
      din = (k <= 10) ? w[10-k] : ~w[0];
      sclk = 1'b0; waitn(8);
    end
    exp_ctrl = w;
    chk(ctrl_word === w, "R7 R8 committed word", ctrl_word, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitn(4);
    rst_n = 1'b1;
    waitn(6);
    // R1 reset state
    chk(dout_oe === 1'b0, "R1 oe after reset", dout_oe, 0);
    chk(dout === 1'b0, "R1 dout after reset", dout, 0);
    chk(ctrl_word === 10'h000, "R1 ctrl after reset", ctrl_word, 0);

    // R2 clocks without an armed frame do nothing
    load_result(10'h2A5);
    for (int k = 0; k < 15; k++) begin
      sclk = 1'b1; din = 1'b1; waitn(8);
      chk(dout_oe === 1'b0, "R2 unarmed oe", dout_oe, 0);
      sclk = 1'b0; waitn(8);
      chk(ctrl_word === 10'h000, "R2 unarmed ctrl", ctrl_word, 0);
    end

    // R3 R4 R5 read sweep, two extra clocks past the release
    for (int v = 0; v < 1024; v += 37) begin
      load_result(10'(v));
      arm_read();
      rd_bits(10'(v), 1, 13);
    end
    load_result(10'h3FF); arm_read(); rd_bits(10'h3FF, 1, 11);
    load_result(10'h200); arm_read(); rd_bits(10'h200, 1, 11);

    // R7 R8 write sweep
    for (int w = 5; w < 1024; w += 41) begin
      arm_write();
      wr_bits(10'(w));
    end

    // R6 new result mid-frame does not disturb the frame in progress
    load_result(10'h155);
    arm_read();
    rd_bits(10'h155, 1, 4);
    res_data = 10'h0F3; res_valid = 1'b1; waitn(1); res_valid = 1'b0;
    rd_bits(10'h155, 5, 11);
    arm_read();
    rd_bits(10'h0F3, 1, 11);  // R6 next read sends the new result

    // R8 short write leaves the control register unchanged
    arm_write();
    for (int k = 1; k <= 8; k++) begin
      sclk = 1'b1; waitn(8); din = ~din; sclk = 1'b0; waitn(8);
    end
    waitn(20);
    chk(ctrl_word === exp_ctrl, "R8 short write ignored", ctrl_word, exp_ctrl);

    // R9 write re-armed mid-frame restarts its count
    arm_write();
    wr_bits(10'h2C3);
    arm_write();
    for (int k = 1; k <= 6; k++) begin
      sclk = 1'b1; waitn(8); din = 1'b1; sclk = 1'b0; waitn(8);
    end
    arm_write();
    wr_bits(10'h13A);
    chk(ctrl_word === 10'h13A, "R9 write restart", ctrl_word, 10'h13A);

    // R9 read re-armed mid-frame releases and restarts
    load_result(10'h36C);
    arm_read();
    rd_bits(10'h36C, 1, 5);
    rfs = 1'b0; waitn(6); rfs = 1'b1; waitn(8);
    chk(dout_oe === 1'b0, "R9 read abort release", dout_oe, 0);
    rd_bits(10'h36C, 1, 12);

    // R10 both strobes on one line
    rfs = 1'b1; tfs = 1'b1; waitn(8);
    for (int p = 0; p < 3; p++) begin
      logic [9:0] wv, rv;
      wv = 10'(99 + p * 301);
      rv = 10'(517 + p * 211);
      load_result(rv);
      rfs = 1'b0; tfs = 1'b0; waitn(8);
      wr_bits(wv);
      chk(ctrl_word === wv, "R10 three-wire write", ctrl_word, wv);
      rfs = 1'b1; tfs = 1'b1; waitn(8);
      rd_bits(rv, 1, 11);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule